// File: doc/BRIEF.md
# Variable-length instruction fetch unit

This block reads a stream of instructions from a byte-wide memory. Each instruction is one opcode byte followed by zero, one or two operand bytes. For every byte, the unit places its program counter on the address lines and pulls the active-low read strobe low for a set number of cycles. It takes the returned byte on the clock edge where the strobe goes back high, and it advances the program counter by one. The opcode alone sets the instruction's length. Operand bytes are packed least significant byte first.

When the last byte of an instruction arrives, the unit presents the opcode, the packed operand and the length with a valid flag. It holds them until a consumer accepts them with a ready handshake, and it starts no new read while it waits. A load input redirects fetching to a new address at any time. It discards whatever was partly fetched.

Top module: `ifu_fetch`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_rd_n` is 1, `ins_valid` is 0 and `mem_addr` equals `RESET_PC` (default 0). The first read uses that address.
- R2: Each byte read keeps `mem_rd_n` low for exactly `STROBE_CYCLES` consecutive cycles, unless a load aborts it. It is then followed by at least one cycle with `mem_rd_n` high.
- R3: The byte is taken from `mem_rdata` as sampled in the last low cycle of the strobe, at the edge where `mem_rd_n` rises. Data present in earlier low cycles is not used.
- R4: `mem_addr` is stable while the strobe is low. It advances by one, modulo 2^16, at each edge that ends a read, so successive reads use consecutive addresses, including across instruction boundaries and across the wrap from 16'hFFFF to 16'h0000.
- R5: The length comes from opcode bits [7:6]. The value 2'b10 means 2 bytes, 2'b11 means 3 bytes, and 2'b00 or 2'b01 means 1 byte. `ins_len` reports the length as the binary values 1, 2 or 3.
- R6: `ins_operand` is 16'h0000 for a 1-byte instruction and {8'h00, second byte} for a 2-byte instruction. For a 3-byte instruction it is {third byte, second byte}.
- R7: While `ins_valid` is 1 and `ins_ready` is 0, `ins_valid`, `ins_opcode`, `ins_operand` and `ins_len` hold their values. `mem_rd_n` stays 1 whenever `ins_valid` is 1.
- R8: After an edge where `ins_valid` and `ins_ready` are both 1, `ins_valid` falls and the next read strobe goes low in the very next cycle.
- R9: `pc_load` at an edge takes priority over everything else. After that edge `ins_valid` is 0, `mem_rd_n` is 1 and the program counter equals `pc_target`. Any partly fetched or unaccepted instruction is dropped, and the next read uses `pc_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_load | input | 1 | Redirect fetching to `pc_target` |
| pc_target | input | 16 | New program counter value for `pc_load` |
| mem_addr | output | 16 | Read address (program counter) |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_rdata | input | 8 | Byte returned by memory |
| ins_valid | output | 1 | Complete instruction available |
| ins_ready | input | 1 | Consumer accepts the instruction |
| ins_opcode | output | 8 | Opcode byte |
| ins_operand | output | 16 | Packed operand, low byte first in memory |
| ins_len | output | 2 | Instruction length in bytes (1 to 3) |

## Verification
The memory model drives real data only in the final low cycle of each strobe and a filler value before it. Capturing a byte too early or too late therefore corrupts the compared opcode or operand. A memory image with mixed 1-, 2- and 3-byte opcodes is fetched with the consumer always ready, which separates length decode and byte packing errors. A stalled consumer tells hold-and-block behaviour apart from overrun. Loads issued during a stall, in the middle of a strobe, and to an address just below the 16-bit wrap tell abort priority, restart address and counter wrap apart from ordinary sequential fetch.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

   // Sequencer states of the fetch unit
   typedef enum logic [1:0] {
      FS_GAP  = 2'd0,   // strobe high, about to start a read
      FS_READ = 2'd1,   // strobe low, waiting for the byte
      FS_HOLD = 2'd2    // instruction complete, waiting for ready
   } fetch_state_e;

endpackage

// File: rtl/ifu_len_decode.sv
module ifu_len_decode #(
   parameter int OPC_W   = 8,
   parameter int LEN_LSB = 6,
   parameter int LEN_W   = 2,
   parameter int MAX_LEN = 3
) (
   input  logic [OPC_W-1:0] opcode,
   output logic [LEN_W-1:0] ins_len
);

   localparam logic [LEN_W-1:0] ONE_BYTE = LEN_W'(1);
   localparam logic [LEN_W-1:0] TWO_BYTE = LEN_W'(2);
   localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_LEN);

   if (LEN_LSB + LEN_W > OPC_W) begin : g_bad_field
      $error("length field lies outside the opcode");
   end

   logic [LEN_W-1:0] field;

   always_comb begin
      field = opcode[LEN_LSB +: LEN_W];
      if (field < TWO_BYTE) begin
         ins_len = ONE_BYTE;
      end else if (field > LEN_MAX) begin
         ins_len = LEN_MAX;
      end else begin
         ins_len = field;
      end
   end

endmodule

// File: rtl/ifu_strobe_timer.sv
module ifu_strobe_timer #(
   parameter int STROBE_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   if (STROBE_CYCLES < 1) begin : g_bad_len
      $error("STROBE_CYCLES must be at least 1");
   end

   if (STROBE_CYCLES == 1) begin : g_single
      assign last = run;
   end else begin : g_count
      localparam int CNT_W = $clog2(STROBE_CYCLES);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYCLES - 1);

      logic [CNT_W-1:0] cnt_q;

      assign last = run && (cnt_q == CNT_LAST);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (run && !last) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end else begin
            cnt_q <= '0;
         end
      end
   end

endmodule

// File: rtl/ifu_operand_asm.sv
module ifu_operand_asm #(
   parameter int BYTE_W     = 8,
   parameter int OPND_BYTES = 2,
   parameter int IDX_W      = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             byte_idx,
   input  logic [BYTE_W-1:0]            din,
   output logic [BYTE_W*OPND_BYTES-1:0] operand
);

   if ((1 << IDX_W) < OPND_BYTES + 1) begin : g_bad_idx
      $error("IDX_W too narrow for the operand byte count");
   end

   // Lane g holds instruction byte g+1; lane 0 is the least significant byte
   for (genvar g = 0; g < OPND_BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            lane_q <= '0;
         end else if (wr_en && byte_idx == IDX_W'(g + 1)) begin
            lane_q <= din;
         end
      end

      assign operand[g*BYTE_W +: BYTE_W] = lane_q;
   end

endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch
   import ifu_pkg::*;
#(
   parameter int          ADDR_W        = 16,
   parameter int          BYTE_W        = 8,
   parameter int          OPND_BYTES    = 2,
   parameter int          STROBE_CYCLES = 3,
   parameter int          LEN_LSB       = 6,
   parameter logic [15:0] RESET_PC      = 16'h0000,
   localparam int         MAX_LEN       = OPND_BYTES + 1,
   localparam int         LEN_W         = $clog2(MAX_LEN + 1),
   localparam int         OPND_W        = BYTE_W * OPND_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_load,
   input  logic [ADDR_W-1:0] pc_target,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_n,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              ins_valid,
   input  logic              ins_ready,
   output logic [BYTE_W-1:0] ins_opcode,
   output logic [OPND_W-1:0] ins_operand,
   output logic [LEN_W-1:0]  ins_len
);

   if (ADDR_W > 16 || ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must lie between 2 and 16");
   end
   if (OPND_BYTES < 1) begin : g_bad_opnd
      $error("OPND_BYTES must be at least 1");
   end

   localparam logic [ADDR_W-1:0] PC_INIT = RESET_PC[ADDR_W-1:0];
   localparam logic [LEN_W-1:0]  IDX_ONE = LEN_W'(1);

   fetch_state_e      state_q, state_d;
   logic [ADDR_W-1:0] pc_q;
   logic [LEN_W-1:0]  idx_q;
   logic [LEN_W-1:0]  len_q;
   logic [BYTE_W-1:0] opcode_q;

   logic              strobe_last;
   logic              capture;
   logic              is_opcode;
   logic              done;
   logic [LEN_W-1:0]  dec_len;
   logic [LEN_W-1:0]  cur_len;

   ifu_strobe_timer #(
      .STROBE_CYCLES (STROBE_CYCLES)
   ) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == FS_READ && !pc_load),
      .last  (strobe_last)
   );

   ifu_len_decode #(
      .OPC_W   (BYTE_W),
      .LEN_LSB (LEN_LSB),
      .LEN_W   (LEN_W),
      .MAX_LEN (MAX_LEN)
   ) len_i (
      .opcode  (mem_rdata),
      .ins_len (dec_len)
   );

   ifu_operand_asm #(
      .BYTE_W     (BYTE_W),
      .OPND_BYTES (OPND_BYTES),
      .IDX_W      (LEN_W)
   ) opnd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (pc_load || (capture && is_opcode)),
      .wr_en    (capture && !is_opcode),
      .byte_idx (idx_q),
      .din      (mem_rdata),
      .operand  (ins_operand)
   );

   // A byte is taken on the edge that ends the strobe
   assign capture   = (state_q == FS_READ) && strobe_last && !pc_load;
   assign is_opcode = (idx_q == '0);
   assign cur_len   = is_opcode ? dec_len : len_q;
   assign done      = (idx_q == cur_len - IDX_ONE);

   always_comb begin
      state_d = state_q;
      if (pc_load) begin
         state_d = FS_GAP;
      end else begin
         unique case (state_q)
            FS_GAP:  state_d = FS_READ;
            FS_READ: if (strobe_last) state_d = done ? FS_HOLD : FS_GAP;
            FS_HOLD: if (ins_ready)   state_d = FS_READ;
            default: state_d = FS_GAP;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= FS_GAP;
         pc_q     <= PC_INIT;
         idx_q    <= '0;
         len_q    <= IDX_ONE;
         opcode_q <= '0;
      end else begin
         state_q <= state_d;
         if (pc_load) begin
            pc_q  <= pc_target;
            idx_q <= '0;
         end else if (capture) begin
            pc_q  <= pc_q + ADDR_W'(1);
            idx_q <= done ? '0 : idx_q + IDX_ONE;
            if (is_opcode) begin
               opcode_q <= mem_rdata;
               len_q    <= dec_len;
            end
         end
      end
   end

   assign mem_addr   = pc_q;
   assign mem_rd_n   = (state_q != FS_READ);
   assign ins_valid  = (state_q == FS_HOLD);
   assign ins_opcode = opcode_q;
   assign ins_len    = len_q;

endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk #(
   parameter int ADDR_W        = 16,
   parameter int BYTE_W        = 8,
   parameter int OPND_W        = 16,
   parameter int LEN_W         = 2,
   parameter int MAX_LEN       = 3,
   parameter int STROBE_CYCLES = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_target,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd_n,
   input logic              ins_valid,
   input logic              ins_ready,
   input logic [BYTE_W-1:0] ins_opcode,
   input logic [OPND_W-1:0] ins_operand,
   input logic [LEN_W-1:0]  ins_len
);

   localparam int CW = $clog2(STROBE_CYCLES + 1) + 1;
   localparam logic [CW-1:0]     CNT_LIM = CW'(STROBE_CYCLES);
   localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);
   localparam logic [LEN_W-1:0]  L_MAX   = LEN_W'(MAX_LEN);

   // Counts earlier consecutive low cycles of the strobe
   logic [CW-1:0] low_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n || mem_rd_n) begin
         low_cnt <= '0;
      end else if (low_cnt != '1) begin
         low_cnt <= low_cnt + CW'(1);
      end
   end

   assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd_n |-> low_cnt < CNT_LIM);

   assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_n && !$past(mem_rd_n)) |-> $stable(mem_addr));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_rd_n) && !$past(pc_load)) |-> mem_addr == $past(mem_addr) + ONE_A);

   assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |-> (ins_len != '0 && ins_len <= L_MAX));

   assert_no_read_while_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |-> mem_rd_n);

   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !ins_ready && !pc_load) |=>
         (ins_valid && $stable(ins_opcode) && $stable(ins_operand) && $stable(ins_len)));

   assert_accept_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && ins_ready && !pc_load) |=> (!ins_valid && !mem_rd_n));

   assert_load_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> (!ins_valid && mem_rd_n && mem_addr == $past(pc_target)));

endmodule

bind ifu_fetch ifu_fetch_chk #(
   .ADDR_W        (ADDR_W),
   .BYTE_W        (BYTE_W),
   .OPND_W        (OPND_W),
   .LEN_W         (LEN_W),
   .MAX_LEN       (MAX_LEN),
   .STROBE_CYCLES (STROBE_CYCLES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .pc_load     (pc_load),
   .pc_target   (pc_target),
   .mem_addr    (mem_addr),
   .mem_rd_n    (mem_rd_n),
   .ins_valid   (ins_valid),
   .ins_ready   (ins_ready),
   .ins_opcode  (ins_opcode),
   .ins_operand (ins_operand),
   .ins_len     (ins_len)
);

// File: tb/ifu_fetch_tb_top.sv
`timescale 1ns/1ps
module ifu_fetch_tb_top;

   localparam int STB = 3;

   typedef struct packed {
      logic [7:0]  op;
      logic [15:0] opnd;
      logic [1:0]  len;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pc_load = 1'b0;
   logic [15:0] pc_target = '0;
   logic [15:0] mem_addr;
   logic        mem_rd_n;
   logic [7:0]  mem_rdata;
   logic        ins_valid;
   logic        ins_ready = 1'b0;
   logic [7:0]  ins_opcode;
   logic [15:0] ins_operand;
   logic [1:0]  ins_len;

   always #2.5 clk = ~clk;

   ifu_fetch #(.STROBE_CYCLES(STB)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pc_load     (pc_load),
      .pc_target   (pc_target),
      .mem_addr    (mem_addr),
      .mem_rd_n    (mem_rd_n),
      .mem_rdata   (mem_rdata),
      .ins_valid   (ins_valid),
      .ins_ready   (ins_ready),
      .ins_opcode  (ins_opcode),
      .ins_operand (ins_operand),
      .ins_len     (ins_len)
   );

   // Memory: true data only in the last low cycle of a strobe (R3)
   logic [7:0] mem [0:255];
   int age = 0;
   always @(posedge clk) age <= mem_rd_n ? 0 : age + 1;
   assign mem_rdata = (!mem_rd_n && age == STB - 1) ? mem[mem_addr[7:0]] : 8'hEE;

   int    n_chk = 0;
   int    n_fail = 0;
   item_t exp_q[$];
   logic [15:0] next_a = 16'h0000;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
      end
   endtask

   // Expected length from opcode bits [7:6] (R5)
   function automatic logic [1:0] len_of(input logic [7:0] op);
      return (op[7:6] >= 2'd2) ? op[7:6] : 2'd1;
   endfunction

   task automatic push_prog(input int count);
      for (int k = 0; k < count; k++) begin
         item_t it;
         it.op   = mem[next_a[7:0]];
         it.len  = len_of(it.op);
         it.opnd = 16'h0000;
         if (it.len >= 2'd2) it.opnd[7:0]  = mem[8'(next_a[7:0] + 8'd1)];
         if (it.len == 2'd3) it.opnd[15:8] = mem[8'(next_a[7:0] + 8'd2)];
         exp_q.push_back(it);
         next_a = next_a + 16'(it.len);
      end
   endtask

   task automatic wait_drain();
      while (exp_q.size() != 0) @(posedge clk);
      #1;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Monitor / scoreboard
   logic        prev_rd = 1'b1;
   logic        prev_hs = 1'b0;
   logic        prev_stall = 1'b0;
   logic        pulse_abort = 1'b0;
   int          low_cnt = 0;
   logic [15:0] exp_addr = 16'h0000;
   item_t       held;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_rd_n && prev_rd) begin
            chk(mem_addr == exp_addr, "R4 read address", mem_addr, exp_addr);
            exp_addr = mem_addr + 16'd1;
            low_cnt = 1;
            pulse_abort = 1'b0;
         end else if (!mem_rd_n) begin
            low_cnt++;
         end else if (!prev_rd && !pulse_abort) begin
            chk(low_cnt == STB, "R2 strobe width", low_cnt, STB);
         end
         if (prev_hs) begin
            chk(!mem_rd_n && !ins_valid, "R8 restart after accept",
                {ins_valid, mem_rd_n}, 2'b00);
         end
         prev_hs = 1'b0;
         if (prev_stall) begin
            chk(ins_valid, "R7 valid held", ins_valid, 1);
            chk({ins_opcode, ins_operand, ins_len} == held, "R7 fields held",
                {ins_opcode, ins_operand, ins_len}, held);
         end
         if (ins_valid) chk(mem_rd_n, "R7 no read while valid", mem_rd_n, 1);
         prev_stall = 1'b0;
         if (ins_valid && !pc_load) begin
            if (ins_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R5 unexpected instruction", ins_opcode, 0);
               end else begin
                  item_t e;
                  e = exp_q.pop_front();
                  chk(ins_opcode == e.op, "R3 opcode", ins_opcode, e.op);
                  chk(ins_len == e.len, "R5 length", ins_len, e.len);
                  chk(ins_operand == e.opnd, "R6 operand", ins_operand, e.opnd);
               end
               prev_hs = 1'b1;
            end else begin
               prev_stall = 1'b1;
               held = {ins_opcode, ins_operand, ins_len};
            end
         end
         if (pc_load) begin
            exp_addr = pc_target;
            if (!mem_rd_n) pulse_abort = 1'b1;
            prev_hs = 1'b0;
            prev_stall = 1'b0;
         end
         prev_rd = mem_rd_n;
      end
   end

   // Driver
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
      mem[8'hFE] = 8'hC5;
      mem[8'hFF] = 8'h34;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(mem_rd_n && !ins_valid && mem_addr == 16'h0000, "R1 reset state",
          {mem_rd_n, ins_valid, mem_addr}, {1'b1, 1'b0, 16'h0000});
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(mem_rd_n && !ins_valid && mem_addr == 16'h0000, "R1 first cycle",
          {mem_rd_n, ins_valid, mem_addr}, {1'b1, 1'b0, 16'h0000});

      // Free-flowing fetch of mixed lengths (R3, R5, R6, R8)
      push_prog(10);
      @(posedge clk); #1 ins_ready = 1'b1;
      wait_drain();
      ins_ready = 1'b0;

      // Consumer stall (R7)
      push_prog(4);
      @(negedge clk);
      while (!ins_valid) @(negedge clk);
      repeat (6) @(posedge clk);
      #1 ins_ready = 1'b1;
      wait_drain();
      ins_ready = 1'b0;

      // Load while an instruction is held (R9)
      repeat (8) @(posedge clk);
      #1 pc_load = 1'b1; pc_target = 16'h0040;
      exp_q.delete(); next_a = 16'h0040;
      push_prog(6);
      @(posedge clk); #1 pc_load = 1'b0; ins_ready = 1'b1;
      wait_drain();

      // Load in the middle of a strobe, to just below the wrap (R9, R4)
      @(posedge clk); #1 pc_load = 1'b1; pc_target = 16'hFFFE;
      exp_q.delete(); next_a = 16'hFFFE;
      push_prog(5);
      @(posedge clk); #1 pc_load = 1'b0;
      wait_drain();

      // Load after a second strobe falls, ready held high (R9)
      @(negedge clk); while (mem_rd_n) @(negedge clk);
      @(negedge clk); while (!mem_rd_n) @(negedge clk);
      @(negedge clk); while (mem_rd_n) @(negedge clk);
      @(posedge clk); #1 pc_load = 1'b1; pc_target = 16'h0081;
      exp_q.delete(); next_a = 16'h0081;
      push_prog(4);
      @(posedge clk); #1 pc_load = 1'b0;
      wait_drain();
      ins_ready = 1'b0;
      repeat (4) @(posedge clk);
      chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule